// File: doc/BRIEF.md
# Prescaled 8-bit Interval Timer

This block is an 8-bit up-counter that advances once per prescaled tick, where the tick rate is the system clock divided by a power of two fixed at elaboration. A small command port, driven by a 4-bit processor datapath, can load a full byte, overwrite either nibble, start the count and stop it. Any nibble of the count can be read back combinationally through a 4-bit read port.

When the count steps from FFH to 00H, the counter keeps running. The same edge sets a sticky overflow flag and emits a one-cycle interrupt request pulse. The flag is cleared by an interrupt acknowledge strobe or by a test-and-clear strobe, which comes from a conditional branch on the flag. If an overflow and a clear land in the same cycle, the overflow wins.

The CPU, the interrupt controller and instruction fetch are outside this block. They drive the strobes and consume the flag and the pulse.

Top module: `ivt_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 00H, the timer stops, and `ovf_flag_o` and `irq_o` become 0. After reset, the count stays at 00H until a command arrives.
- R2: `cmd_i` = 1 (load) writes `imm_i` into the count at the next edge. `rd_nib_o` shows count bits 3:0 when `rd_hi_i` = 0 and bits 7:4 when `rd_hi_i` = 1.
- R3: `cmd_i` = 2 writes `nib_i` into count bits 3:0, and `cmd_i` = 3 writes it into bits 7:4; the other nibble is kept. When the timer is running, the write takes effect at the next edge and does not restart the prescaler.
- R4: `cmd_i` = 4 (start) clears the prescaler and runs the timer. The first increment falls 2^DIV_EXP clocks after the start edge, and later increments follow every 2^DIV_EXP clocks. DIV_EXP must be in 0..13 and must not be 6; any other value is rejected at elaboration.
- R5: `cmd_i` = 5 (stop) freezes the count. Codes 0, 6 and 7 do nothing.
- R6: On an increment from FFH, the count becomes 00H and counting continues. At that same edge `ovf_flag_o` is set and `irq_o` is high for exactly one cycle.
- R7: A high `irq_ack_i` or `flag_test_i` clears `ovf_flag_o` at the next edge.
- R8: If an overflow and a clear strobe fall in the same cycle, `ovf_flag_o` ends at 1.
- R9: A load or nibble write issued in the cycle that a tick is due takes the written value. That tick is dropped and raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 idle, 1 load byte, 2 write low nibble, 3 write high nibble, 4 start, 5 stop |
| imm_i | input | 8 | Byte for the load command |
| nib_i | input | 4 | Nibble for the nibble writes |
| rd_hi_i | input | 1 | Read select: 0 low nibble, 1 high nibble |
| rd_nib_o | output | 4 | Selected nibble of the count |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| flag_test_i | input | 1 | Branch test-and-clear strobe |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | One-cycle overflow interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an overflow and a flag clear. The bench starts from FFH with the flag already set and holds the acknowledge high in exactly the cycle whose edge wraps the count; the flag must still read 1. The second pair is a write and a due tick. The bench lets the prescaler run for one period less one clock and then issues a low-nibble write, so the write meets the tick. It judges this case by the written value holding for a full further period before the next increment.

// File: rtl/ivt_pkg.sv
// Shared command encoding for the prescaled interval timer.
package ivt_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_LOAD  = 3'd1,
        CMD_WR_LO = 3'd2,
        CMD_WR_HI = 3'd3,
        CMD_START = 3'd4,
        CMD_STOP  = 3'd5
    } ivt_cmd_e;
endpackage

// File: rtl/ivt_prescale.sv
// Run state and power-of-two prescaler.
// Produces one tick every 2^DIV_EXP clocks while running. A start
// command clears the prescaler. Assumes start and stop never arrive
// together. The tick is suppressed in a start or stop cycle.
module ivt_prescale #(
    parameter int DIV_EXP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic run_o,
    output logic tick_o
);
    // Run state: set by start, cleared by stop or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_o <= 1'b0;
        else if (start_i) run_o <= 1'b1;
        else if (stop_i)  run_o <= 1'b0;
    end

    generate
        if ((DIV_EXP < 0) || (DIV_EXP > 13) || (DIV_EXP == 6)) begin : g_bad_exp
            $error("ivt_prescale: DIV_EXP must be 0..13 and not 6");
        end

        if (DIV_EXP == 0) begin : g_undivided
            // Undivided: one tick per running clock.
            always_comb tick_o = run_o && !start_i && !stop_i;
        end else begin : g_divided
            logic [DIV_EXP-1:0] pre_q;

            // Prescale count: cleared on start, advances while running.
            always_ff @(posedge clk) begin
                if (!rst_n)       pre_q <= '0;
                else if (start_i) pre_q <= '0;
                else if (run_o)   pre_q <= pre_q + 1'b1;
            end

            // Tick in the last cycle of each prescale period.
            always_comb tick_o = run_o && (&pre_q) && !start_i && !stop_i;

            a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
                start_i |=> (pre_q == '0));
            a_r5_stop_halts_prescaler: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_o && !start_i) |=> $stable(pre_q));
        end
    endgenerate
endmodule

// File: rtl/ivt_count.sv
// The count register, built from two nibbles.
// Writes take priority over a tick in the same cycle, and a tick
// dropped this way raises no wrap. wrap_o marks an increment from
// the all-ones value.
module ivt_count #(
    parameter int NIB_W = 4,
    localparam int CNT_W = 2 * NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [CNT_W-1:0] byte_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic any_wr;

    // Detect writes and wraps.
    always_comb begin
        any_wr = load_i || wr_lo_i || wr_hi_i;
        wrap_o = tick_i && (&count_o) && !any_wr;
    end

    // Count register: write first, else increment on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_o <= '0;
        else if (load_i)  count_o <= byte_i;
        else if (wr_lo_i) count_o[NIB_W-1:0] <= nib_i;
        else if (wr_hi_i) count_o[CNT_W-1:NIB_W] <= nib_i;
        else if (tick_i)  count_o <= count_o + 1'b1;
    end

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_o == '0));
    a_r3_lo_write_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !load_i) |=> (count_o[CNT_W-1:NIB_W] == $past(count_o[CNT_W-1:NIB_W])));
    a_r3_hi_write_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !load_i && !wr_lo_i) |=> (count_o[NIB_W-1:0] == $past(count_o[NIB_W-1:0])));
endmodule

// File: rtl/ivt_flag.sv
// Sticky overflow flag and a one-cycle interrupt pulse.
// When set and clear fall in the same cycle, set wins.
module ivt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic ack_i,
    input  logic test_i,
    output logic flag_o,
    output logic irq_o
);
    // Flag: set by wrap, cleared by either strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_o <= 1'b0;
        else if (wrap_i)           flag_o <= 1'b1;
        else if (ack_i || test_i)  flag_o <= 1'b0;
    end

    // Interrupt request: one cycle per wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= wrap_i;
    end

    a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o);
    a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_i && (ack_i || test_i)) |=> !flag_o);
    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    a_r6_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);
endmodule

// File: rtl/ivt_top.sv
// Top level of the prescaled 8-bit interval timer.
// Decodes the command code, wires the prescaler, the count and the
// flag, and muxes the selected nibble to the read port.
module ivt_top #(
    parameter int DIV_EXP = 2,
    parameter int NIB_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cmd_i,
    input  logic [2*NIB_W-1:0] imm_i,
    input  logic [NIB_W-1:0]   nib_i,
    input  logic               rd_hi_i,
    output logic [NIB_W-1:0]   rd_nib_o,
    input  logic               irq_ack_i,
    input  logic               flag_test_i,
    output logic               ovf_flag_o,
    output logic               irq_o
);
    import ivt_pkg::*;
    localparam int CNT_W = 2 * NIB_W;

    ivt_cmd_e         cmd;
    logic             do_load, do_lo, do_hi, do_start, do_stop;
    logic             run_w, tick_w, wrap_w;
    logic [CNT_W-1:0] count_w;

    // Command decode: one strobe per command code.
    always_comb begin
        cmd      = ivt_cmd_e'(cmd_i);
        do_load  = (cmd == CMD_LOAD);
        do_lo    = (cmd == CMD_WR_LO);
        do_hi    = (cmd == CMD_WR_HI);
        do_start = (cmd == CMD_START);
        do_stop  = (cmd == CMD_STOP);
    end

    ivt_prescale #(.DIV_EXP(DIV_EXP)) u_pre (
        .clk(clk), .rst_n(rst_n), .start_i(do_start), .stop_i(do_stop),
        .run_o(run_w), .tick_o(tick_w)
    );

    ivt_count #(.NIB_W(NIB_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(do_load), .wr_lo_i(do_lo),
        .wr_hi_i(do_hi), .byte_i(imm_i), .nib_i(nib_i), .tick_i(tick_w),
        .count_o(count_w), .wrap_o(wrap_w)
    );

    ivt_flag u_flag (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap_w), .ack_i(irq_ack_i),
        .test_i(flag_test_i), .flag_o(ovf_flag_o), .irq_o(irq_o)
    );

    // Read mux: the selected nibble of the count.
    always_comb rd_nib_o = rd_hi_i ? count_w[CNT_W-1:NIB_W] : count_w[NIB_W-1:0];

    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !do_load && !do_lo && !do_hi) |=> $stable(count_w));
    a_r9_write_blocks_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (do_load || do_lo || do_hi) |=> !irq_o);
endmodule

// File: tb/test_ivt_top.sv
module test_ivt_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_EXP    = 2;
    localparam int NVEC       = 6;

    // Vector: {load value, clocks after start, expected count, expected flag}
    localparam logic [24:0] VEC [NVEC] = '{
        {8'h10, 8'd8,  8'h12, 1'b0},
        {8'hFE, 8'd8,  8'h00, 1'b1},
        {8'hFF, 8'd3,  8'hFF, 1'b0},
        {8'hFF, 8'd4,  8'h00, 1'b1},
        {8'h00, 8'd20, 8'h05, 1'b0},
        {8'hF0, 8'd64, 8'h00, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = 3'd0;
    logic [7:0] imm_i = 8'h00;
    logic [3:0] nib_i = 4'h0;
    logic       rd_hi_i = 1'b0;
    logic [3:0] rd_nib_o;
    logic       irq_ack_i = 1'b0;
    logic       flag_test_i = 1'b0;
    logic       ovf_flag_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_top #(.DIV_EXP(DIV_EXP)) i_ivt_top (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .imm_i(imm_i), .nib_i(nib_i),
        .rd_hi_i(rd_hi_i), .rd_nib_o(rd_nib_o), .irq_ack_i(irq_ack_i),
        .flag_test_i(flag_test_i), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_count(output logic [7:0] v);
        rd_hi_i = 1'b0; #1; v[3:0] = rd_nib_o;
        rd_hi_i = 1'b1; #1; v[7:4] = rd_nib_o;
        rd_hi_i = 1'b0;
    endtask

    task automatic do_cmd(input logic [2:0] c, input logic [7:0] b, input logic [3:0] n);
        cmd_i = c; imm_i = b; nib_i = n;
        @(negedge clk);
        cmd_i = 3'd0;
    endtask

    task automatic pulse_ack();
        irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
    endtask

    task automatic check_count(input string req, input logic [7:0] exp);
        logic [7:0] v;
        read_count(v);
        check(req, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_count("R1 count after reset", 8'h00);
        check("R1 flag after reset", {7'd0, ovf_flag_o}, 8'd0);
        check("R1 irq after reset", {7'd0, irq_o}, 8'd0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check_count("R1 stopped after reset", 8'h00);

        // Vector walk: R2 load, R4 tick period, R6 wrap and flag
        for (int i = 0; i < NVEC; i++) begin
            do_cmd(3'd5, 8'h00, 4'h0);
            pulse_ack();
            do_cmd(3'd1, VEC[i][24:17], 4'h0);
            check_count("R2 loaded value", VEC[i][24:17]);
            do_cmd(3'd4, 8'h00, 4'h0);
            repeat (int'(VEC[i][16:9])) @(negedge clk);
            check_count("R4 count after run", VEC[i][8:1]);
            check("R6 flag after run", {7'd0, ovf_flag_o}, {7'd0, VEC[i][0]});
        end

        // R6: irq pulse on wrap
        do_cmd(3'd5, 8'h00, 4'h0);
        pulse_ack();
        do_cmd(3'd1, 8'hFF, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (3) @(negedge clk);
        check("R6 no irq before wrap", {7'd0, irq_o}, 8'd0);
        @(negedge clk);
        check("R6 irq at wrap", {7'd0, irq_o}, 8'd1);
        check("R6 flag at wrap", {7'd0, ovf_flag_o}, 8'd1);
        check_count("R6 wrapped to zero", 8'h00);
        @(negedge clk);
        check("R6 irq one cycle", {7'd0, irq_o}, 8'd0);
        check("R6 flag sticky", {7'd0, ovf_flag_o}, 8'd1);

        // R7: test strobe clears the flag
        flag_test_i = 1'b1; @(negedge clk); flag_test_i = 1'b0;
        check("R7 test strobe clears", {7'd0, ovf_flag_o}, 8'd0);

        // R8: set wins over a clear in the same cycle
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd1, 8'hFF, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (4) @(negedge clk);
        check("R8 flag set before", {7'd0, ovf_flag_o}, 8'd1);
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd1, 8'hFF, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (3) @(negedge clk);
        pulse_ack();
        check("R8 set wins over ack", {7'd0, ovf_flag_o}, 8'd1);
        check_count("R8 wrap happened", 8'h00);
        pulse_ack();
        check("R7 ack clears", {7'd0, ovf_flag_o}, 8'd0);

        // R9: write in the tick cycle drops the tick
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd1, 8'h30, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (3) @(negedge clk);
        do_cmd(3'd2, 8'h00, 4'h7);
        check_count("R9 write beats tick", 8'h37);
        repeat (3) @(negedge clk);
        check_count("R9 held through period", 8'h37);
        @(negedge clk);
        check_count("R9 next tick", 8'h38);

        // R9: write over FFH in the tick cycle raises no overflow
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd1, 8'hFF, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (3) @(negedge clk);
        do_cmd(3'd3, 8'h00, 4'hF);
        check("R9 no overflow on write", {7'd0, ovf_flag_o}, 8'd0);
        check_count("R9 written value kept", 8'hFF);

        // R3: running nibble write keeps prescaler phase
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd1, 8'h20, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (2) @(negedge clk);
        do_cmd(3'd2, 8'h00, 4'h5);
        check_count("R3 low write while running", 8'h25);
        @(negedge clk);
        check_count("R3 prescaler not restarted", 8'h26);
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd3, 8'h00, 4'hA);
        check_count("R3 high write keeps low", 8'hA6);
        do_cmd(3'd2, 8'h00, 4'hC);
        check_count("R3 low write keeps high", 8'hAC);

        // R4: start restarts the prescaler
        do_cmd(3'd1, 8'h50, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (2) @(negedge clk);
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        check_count("R4 no tick after restart", 8'h50);
        repeat (3) @(negedge clk);
        check_count("R4 full period after restart", 8'h50);
        @(negedge clk);
        check_count("R4 first tick", 8'h51);
        repeat (4) @(negedge clk);
        check_count("R4 second tick", 8'h52);

        // R5: stop freezes, idle codes are ignored
        do_cmd(3'd5, 8'h00, 4'h0);
        do_cmd(3'd6, 8'h99, 4'h9);
        do_cmd(3'd7, 8'h99, 4'h9);
        repeat (20) @(negedge clk);
        check_count("R5 frozen after stop", 8'h52);

        // R1: reset while running clears everything
        do_cmd(3'd1, 8'hFF, 4'h0);
        do_cmd(3'd4, 8'h00, 4'h0);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 flag cleared by reset", {7'd0, ovf_flag_o}, 8'd0);
        repeat (8) @(negedge clk);
        read_count(v);
        check("R1 stopped by reset", v, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule